// File: doc/BRIEF.md
# Keyboard and Display Console Port

This peripheral sits on a 16-bit processor memory bus and gives software a polled or interrupt-driven path to a keyboard and a character display. It has four device registers. Two are status words, each with a ready flag and an interrupt enable. One holds the last captured keystroke. A write to the fourth sends one character to the display. The block raises a select output whenever the address falls in the I/O window. The bus logic uses it to take read data from this block instead of from memory.

On the keyboard side a byte arrives with a one-cycle strobe. It is captured only when the previous character has already been consumed. On the display side a byte is offered with a valid flag, which stays up until the display acknowledges it. The read and write traffic has side effects. Reading the keyboard data register re-arms capture. A write to the display is accepted only while the display is ready.

Top module: `console_mmio`

## Requirements
- R1: After reset, keyboard status reads 0x0000, display status reads 0x8000, dispValid is 0, and both interrupt requests are 0.
- R2: ioSel is 1 exactly when busAddr >= 0xFE00. busRdata is 0 for any address other than 0xFE00 (keyboard status), 0xFE02 (keyboard data) and 0xFE04 (display status). This includes 0xFE06 and addresses outside the window. busRdata follows busAddr combinationally and does not depend on busRd.
- R3: A keyStrobe at a clock edge while keyboard ready (status bit 15) is 0 stores keyByte. From the next cycle, status bit 15 reads 1 and keyboard data reads {8'h00, keyByte}.
- R4: While keyboard ready is 1, strobes are dropped and the stored byte is unchanged.
- R5: A bus read (busRd=1) of 0xFE02 while keyboard ready is 1 clears keyboard ready at that edge. The next strobe is then captured.
- R6: A write to either status register changes only its bit 14, the interrupt enable. Bit 15 and the other bits are unaffected, and the unused bits read 0. Writes to 0xFE02 have no effect.
- R7: keyIrq equals keyboard ready AND keyboard enable. dispIrq equals display ready AND display enable.
- R8: A write to 0xFE06 while display ready is 1 drives dispByte = busWdata[7:0] and dispValid = 1 from the next cycle, and display status bit 15 reads 0.
- R9: A write to 0xFE06 while display ready is 0 is discarded. dispByte is unchanged, and no further byte is offered after the acknowledge.
- R10: dispValid and dispByte hold until an edge with dispAck=1, after which dispValid is 0. Display ready reads 1 one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bus address |
| busRd | input | 1 | Read enable; triggers read side effects |
| busWr | input | 1 | Write enable |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the addressed device register |
| ioSel | output | 1 | Address hits the I/O window |
| keyByte | input | 8 | Character from keyboard |
| keyStrobe | input | 1 | keyByte valid this cycle |
| dispByte | output | 8 | Character offered to display |
| dispValid | output | 1 | dispByte valid, waiting for ack |
| dispAck | input | 1 | Display has taken dispByte |
| keyIrq | output | 1 | Keyboard interrupt request |
| dispIrq | output | 1 | Display interrupt request |

## Verification
On every cycle the assertions check the following: a pending keystroke is held against later strobes, a data read clears ready, enable writes land, both requests stay consistent with their ready and enable bits, and busy display writes leave the offered byte untouched. They also check that the valid/ack handshake holds its byte and returns ready one cycle after the acknowledge, and that no data leaks onto the bus outside the window. Only the bench scenarios show that every character code travels intact in both directions. The same applies to the exact cycle in which each status bit changes, the full-address decode, including odd and aliasing addresses, and the fact that a discarded display write never surfaces later.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_KSTAT, RD_KDATA, RD_DSTAT} rdSel_t;

  typedef struct packed {
    logic   kStatWr;
    logic   kDataRd;
    logic   dStatWr;
    logic   dLoad;
    logic   dReady;
    rdSel_t rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/console_ctrl.sv
module console_ctrl
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IO_BASE    = 16'hFE00,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dispAck,
  output ctrlStrobe_t       strobe,
  output logic              ioSel,
  output logic              dispValid
);
  typedef enum logic [1:0] {D_IDLE, D_SEND, D_SETTLE} dState_t;

  dState_t dState;
  dState_t dNext;
  logic    hitKstat;
  logic    hitKdata;
  logic    hitDstat;
  logic    hitDdata;

  assign ioSel    = (busAddr >= IO_BASE);
  assign hitKstat = (busAddr == KSTAT_ADDR);
  assign hitKdata = (busAddr == KDATA_ADDR);
  assign hitDstat = (busAddr == DSTAT_ADDR);
  assign hitDdata = (busAddr == DDATA_ADDR);

  always_comb begin
    strobe.kStatWr = busWr && hitKstat;
    strobe.kDataRd = busRd && hitKdata;
    strobe.dStatWr = busWr && hitDstat;
    strobe.dReady  = (dState == D_IDLE);
    strobe.dLoad   = busWr && hitDdata && (dState == D_IDLE);
    if (hitKstat)      strobe.rdSel = RD_KSTAT;
    else if (hitKdata) strobe.rdSel = RD_KDATA;
    else if (hitDstat) strobe.rdSel = RD_DSTAT;
    else               strobe.rdSel = RD_NONE;
  end

  always_comb begin
    dNext = dState;
    case (dState)
      D_IDLE:   if (strobe.dLoad) dNext = D_SEND;
      D_SEND:   if (dispAck) dNext = D_SETTLE;
      D_SETTLE: dNext = D_IDLE;
      default:  dNext = D_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) dState <= D_IDLE;
    else       dState <= dNext;
  end

  assign dispValid = (dState == D_SEND);
endmodule

// File: rtl/console_dp.sv
module console_dp
  import console_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CHAR_W-1:0] keyByte,
  input  logic              keyStrobe,
  output logic [DATA_W-1:0] busRdata,
  output logic [CHAR_W-1:0] dispByte,
  output logic              keyRdy,
  output logic              keyEn,
  output logic              dispEn,
  output logic [CHAR_W-1:0] keyData,
  output logic              keyIrq,
  output logic              dispIrq
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IEN_BIT = DATA_W - 2;
  localparam int PAD_W   = DATA_W - CHAR_W;

  logic [DATA_W-1:0] kStatWord;
  logic [DATA_W-1:0] dStatWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyRdy  <= 1'b0;
      keyData <= '0;
    end else if (!keyRdy && keyStrobe) begin
      keyRdy  <= 1'b1;
      keyData <= keyByte;
    end else if (strobe.kDataRd) begin
      keyRdy  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyEn    <= 1'b0;
      dispEn   <= 1'b0;
      dispByte <= '0;
    end else begin
      if (strobe.kStatWr) keyEn  <= busWdata[IEN_BIT];
      if (strobe.dStatWr) dispEn <= busWdata[IEN_BIT];
      if (strobe.dLoad)   dispByte <= busWdata[CHAR_W-1:0];
    end
  end

  always_comb begin
    kStatWord          = '0;
    kStatWord[RDY_BIT] = keyRdy;
    kStatWord[IEN_BIT] = keyEn;
    dStatWord          = '0;
    dStatWord[RDY_BIT] = strobe.dReady;
    dStatWord[IEN_BIT] = dispEn;
    case (strobe.rdSel)
      RD_KSTAT: busRdata = kStatWord;
      RD_KDATA: busRdata = {{PAD_W{1'b0}}, keyData};
      RD_DSTAT: busRdata = dStatWord;
      default:  busRdata = '0;
    endcase
  end

  assign keyIrq  = keyRdy && keyEn;
  assign dispIrq = strobe.dReady && dispEn;
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              ioSel,
  input  logic [CHAR_W-1:0] keyByte,
  input  logic              keyStrobe,
  output logic [CHAR_W-1:0] dispByte,
  output logic              dispValid,
  input  logic              dispAck,
  output logic              keyIrq,
  output logic              dispIrq
);
  ctrlStrobe_t       strobe;
  logic              keyRdy;
  logic              keyEn;
  logic              dispEn;
  logic              dispRdy;
  logic [CHAR_W-1:0] keyData;

  console_ctrl #(.ADDR_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .dispAck(dispAck), .strobe(strobe), .ioSel(ioSel), .dispValid(dispValid)
  );

  console_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .keyByte(keyByte), .keyStrobe(keyStrobe), .busRdata(busRdata),
    .dispByte(dispByte), .keyRdy(keyRdy), .keyEn(keyEn), .dispEn(dispEn),
    .keyData(keyData), .keyIrq(keyIrq), .dispIrq(dispIrq)
  );

  assign dispRdy = strobe.dReady;
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [DATA_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [DATA_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [DATA_W-1:0] DDATA_ADDR = 16'hFE06
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              ioSel,
  input logic              keyIrq,
  input logic              dispIrq,
  input logic              dispValid,
  input logic              dispAck,
  input logic [CHAR_W-1:0] dispByte,
  input logic              keyRdy,
  input logic              keyEn,
  input logic              dispEn,
  input logic              dispRdy,
  input logic [CHAR_W-1:0] keyData
);
  localparam int IEN_BIT = DATA_W - 2;

  p_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ioSel |-> (busRdata == '0));

  p_key_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyRdy && !(busRd && busAddr == KDATA_ADDR)) |=> (keyRdy && $stable(keyData)));

  p_key_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (keyRdy && busRd && busAddr == KDATA_ADDR) |=> !keyRdy);

  p_ken_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == KSTAT_ADDR) |=> (keyEn == $past(busWdata[IEN_BIT])));

  p_kirq_r7: assert property (@(posedge clk) disable iff (!rstN)
    keyIrq |-> (keyRdy && keyEn));

  p_dirq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dispRdy && dispEn) |-> dispIrq);

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!dispRdy && busWr && busAddr == DDATA_ADDR) |=> $stable(dispByte));

  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispAck) |=> (dispValid && $stable(dispByte)));

  p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispAck) |=> !dispValid);

  p_ready_back_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dispValid) |=> dispRdy);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> !dispRdy);
endmodule

bind console_mmio console_mmio_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busWdata(busWdata), .busRdata(busRdata), .ioSel(ioSel), .keyIrq(keyIrq),
  .dispIrq(dispIrq), .dispValid(dispValid), .dispAck(dispAck),
  .dispByte(dispByte), .keyRdy(keyRdy), .keyEn(keyEn), .dispEn(dispEn),
  .dispRdy(dispRdy), .keyData(keyData)
);

// File: tb/sim_console_mmio.sv
`timescale 1ns/1ps
module sim_console_mmio;
  localparam logic [15:0] A_KS = 16'hFE00;
  localparam logic [15:0] A_KD = 16'hFE02;
  localparam logic [15:0] A_DS = 16'hFE04;
  localparam logic [15:0] A_DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] busAddr;
  logic        busRd;
  logic        busWr;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic        ioSel;
  logic [7:0]  keyByte;
  logic        keyStrobe;
  logic [7:0]  dispByte;
  logic        dispValid;
  logic        dispAck;
  logic        keyIrq;
  logic        dispIrq;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  console_mmio u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .ioSel(ioSel),
    .keyByte(keyByte), .keyStrobe(keyStrobe), .dispByte(dispByte),
    .dispValid(dispValid), .dispAck(dispAck), .keyIrq(keyIrq), .dispIrq(dispIrq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #0.5;
  endtask

  task automatic peek(input logic [15:0] a, output logic [15:0] v);
    busAddr = a;
    #0.25;
    v = busRdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    cyc();
    busWr = 1'b0;
  endtask

  logic [15:0] v;
  logic [15:0] expv;

  initial begin
    rstN = 0; busAddr = 0; busRd = 0; busWr = 0; busWdata = 0;
    keyByte = 0; keyStrobe = 0; dispAck = 0;
    repeat (3) cyc();
    // R1 reset state
    peek(A_KS, v); chk("R1 kstat", v, 16'h0000);
    peek(A_DS, v); chk("R1 dstat", v, 16'h8000);
    chk("R1 valid", {15'b0, dispValid}, 16'h0);
    chk("R1 irqs", {14'b0, keyIrq, dispIrq}, 16'h0);
    rstN = 1;
    cyc();

    // capture one key so the decode sweep sees non-zero data
    keyByte = 8'h5A; keyStrobe = 1; cyc(); keyStrobe = 0;

    // R2 address sweep, no clock side effects (busRd=0, busWr=0)
    for (int a = 0; a < 65536; a += ((a < 16'hFD00) ? 251 : 1)) begin
      peek(a[15:0], v);
      case (a[15:0])
        A_KS:    expv = 16'h8000;
        A_KD:    expv = 16'h005A;
        A_DS:    expv = 16'h8000;
        default: expv = 16'h0000;
      endcase
      chk("R2 rdata", v, expv);
      chk("R2 ioSel", {15'b0, ioSel}, {15'b0, (a >= 16'hFE00)});
    end
    cyc();

    // R6 writes to keyboard data ignored
    wr(A_KD, 16'hFFFF);
    peek(A_KD, v); chk("R6 kdata write ignored", v, 16'h005A);
    // R5 consume it
    busAddr = A_KD; busRd = 1; #0.25;
    chk("R5 read value", busRdata, 16'h005A);
    cyc(); busRd = 0;
    peek(A_KS, v); chk("R5 ready cleared", v, 16'h0000);

    // R3/R4/R5 sweep over every character code
    for (int b = 0; b < 256; b++) begin
      keyByte = b[7:0]; keyStrobe = 1; cyc(); keyStrobe = 0;
      peek(A_KS, v); chk("R3 ready set", v, 16'h8000);
      peek(A_KD, v); chk("R3 data", v, {8'h00, b[7:0]});
      keyByte = ~b[7:0]; keyStrobe = 1; cyc(); keyStrobe = 0;
      peek(A_KD, v); chk("R4 drop", v, {8'h00, b[7:0]});
      busAddr = A_KD; busRd = 1; cyc(); busRd = 0;
      peek(A_KS, v); chk("R5 clear", v, 16'h0000);
    end

    // R5 read of an empty register has no effect, next strobe still captured
    busAddr = A_KD; busRd = 1; cyc(); busRd = 0;
    keyByte = 8'hC3; keyStrobe = 1; cyc(); keyStrobe = 0;
    peek(A_KD, v); chk("R5 rearmed", v, 16'h00C3);

    // R6/R7 enable sweep: keyboard ready=1 now
    for (int en = 0; en < 2; en++) begin
      wr(A_KS, (en != 0) ? 16'hFFFF : 16'hBFFF);
      peek(A_KS, v); chk("R6 kstat", v, {1'b1, en[0], 14'b0});
      chk("R7 keyIrq", {15'b0, keyIrq}, {15'b0, en[0]});
      wr(A_DS, (en != 0) ? 16'h7FFF : 16'h3FFF);
      peek(A_DS, v); chk("R6 dstat", v, {1'b1, en[0], 14'b0});
      chk("R7 dispIrq", {15'b0, dispIrq}, {15'b0, en[0]});
    end
    busAddr = A_KD; busRd = 1; cyc(); busRd = 0;
    chk("R7 keyIrq after clear", {15'b0, keyIrq}, 16'h0);
    wr(A_KS, 16'h0000);

    // R8/R9/R10 sweep; display enable is 1 from above
    for (int b = 0; b < 256; b++) begin
      wr(A_DD, {~b[7:0], b[7:0]});
      chk("R8 valid", {15'b0, dispValid}, 16'h1);
      chk("R8 byte", {8'h00, dispByte}, {8'h00, b[7:0]});
      peek(A_DS, v); chk("R8 ready low", v, 16'h4000);
      chk("R7 dispIrq busy", {15'b0, dispIrq}, 16'h0);
      wr(A_DD, {8'h00, ~b[7:0]});
      chk("R9 byte kept", {8'h00, dispByte}, {8'h00, b[7:0]});
      for (int k = 0; k < (b % 3); k++) cyc();
      chk("R10 valid held", {15'b0, dispValid}, 16'h1);
      dispAck = 1; cyc(); dispAck = 0;
      chk("R10 valid dropped", {15'b0, dispValid}, 16'h0);
      peek(A_DS, v); chk("R10 ready still low", v, 16'h4000);
      cyc();
      peek(A_DS, v); chk("R10 ready back", v, 16'hC000);
      chk("R9 no late offer", {15'b0, dispValid}, 16'h0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule